// File: doc/BRIEF.md
# Three-Axis Tilt Sensor Register and Interrupt Core

This block is the digital register core of a three-axis tilt sensor that a host reaches over a two-wire I2C bus as a slave. The signed sample words for the three axes, and the shake, tap and orientation event strobes, come in as already-digitised ports. The core stores the axis results and an orientation status byte. It holds a writable interrupt-enable byte and a mode byte. From these it drives an interrupt pin whose polarity and drive style are programmable.

The host selects a register by writing a pointer byte. It then writes to that register, or it issues a repeated start and reads a run of consecutive registers. Interrupt sources latch a single pending flag, and that flag holds the pin asserted until the host reads the orientation status byte. A sleep counter watches for inactivity and can put the sensor to sleep. Later activity wakes it and can raise an interrupt.

Top module: `accel_tilt_slave`

## Requirements
- R1: The core acknowledges only the 7-bit slave address 0x4C (address byte 0x98 for write, 0x99 for read). Any other address gets no acknowledge, and the core ignores the rest of that transfer. SDA is pulled low only while SCL is low.
- R2: The first data byte after a write address loads the register pointer. Each further written byte goes to the pointed register, and the pointer then advances by one. Each byte read returns the pointed register, and the pointer then advances by one, so a burst returns consecutive registers.
- R3: Registers 0x00, 0x01 and 0x02 return the X, Y and Z samples. The latest sample is in bits [5:0], a re-read alert is in bit 6, and bit 7 is 0. Samples are stored on each sample strobe.
- R4: If a sample strobe arrives while a byte of an axis register is being read, that axis keeps its old value and its alert bit is set. The next sample strobe outside a read stores the new value and clears the alert.
- R5: Register 0x03 (tilt status) holds front/back in bits [1:0] (01 front, 10 back) and side in bits [4:2] (001 left, 010 right, 101 down, 110 up). It also holds the tap flag in bit 5 and the shake flag in bit 7. Bit 6 reads 0.
- R6: Register 0x06 (interrupt enables) is writable and reads back. From bit 7 down to bit 0 its bits enable X shake, Y shake, Z shake, every sample, sleep exit, tap, side change and front/back change.
- R7: A shake strobe on an axis whose enable bit is set latches the interrupt and sets tilt bit 7. A shake on an axis whose enable bit is clear does neither.
- R8: A change of side raises the interrupt only when bit 1 is set, and a change of front/back only when bit 0 is set. A tap raises it only when bit 2 is set, and each sample strobe only when bit 4 is set. An orientation strobe that repeats the stored values raises nothing.
- R9: Once latched, the interrupt stays pending until a byte of register 0x03 is read. That read clears the pending flag and the tap and shake bits.
- R10: A write to any register other than 0x06 and 0x07 is acknowledged and has no effect.
- R11: Register 0x07 (mode) is writable. The core is active only with bit 0 set and bit 2 clear, and in any other state every sample and event strobe is ignored. Bit 7 set makes the pin active-high (`intOut` = pending), and bit 7 clear makes it active-low. Bit 6 set drives the pin always (`intOe` = 1); bit 6 clear drives it only while `intOut` is low.
- R12: With mode bit 4 set in the active state, each sample strobe (bit 5 clear) or each sixteenth sample strobe (bit 5 set) advances the sleep counter. After SLEEP_LIMIT (default 255) advances, `asleep` rises. Any shake, tap or orientation change clears the counter. With bit 3 set, such activity while asleep clears `asleep` and raises the interrupt if enable bit 3 is set. A mode write clears the counter and `asleep`.
- R13: After reset all registers are 0. `intOut` is 1, and `intOe`, `sdaLow` and `asleep` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | I2C clock line level |
| sdaIn | input | 1 | I2C data line level |
| sdaLow | output | 1 | Pulls the data line low when 1 |
| sampleStrobe | input | 1 | New axis samples are valid |
| sampleX | input | 6 | X sample |
| sampleY | input | 6 | Y sample |
| sampleZ | input | 6 | Z sample |
| shakeStrobe | input | 3 | Shake seen on Z, Y, X (bits 2..0) |
| tapStrobe | input | 1 | Tap seen |
| orientStrobe | input | 1 | Orientation inputs are valid |
| frontBackIn | input | 2 | Front/back code |
| sideIn | input | 3 | Side code |
| intOut | output | 1 | Interrupt pin level |
| intOe | output | 1 | Interrupt pin drive enable |
| asleep | output | 1 | Sleep state |

## Verification
The bench targets the hold-off window. In it, a sample lands after the slave has captured an axis byte for transmit but before the master finishes that byte. A core that ignored the window would show the new value with no alert, or would lose the alert on the next read. The bench also fires a shake on a disabled axis and repeats an unchanged orientation. A core that gated badly would raise the pin or set the shake bit anyway. It checks the sleep counter one strobe short of and exactly at the limit, with both prescaler settings, so an off-by-one or a wrong divide shows up as an early or late `asleep`. It also reads the tilt byte in the middle of the flow and confirms that the pin and the shake and tap flags all clear together.

// File: rtl/accel_pkg.sv
package accel_pkg;
  typedef struct packed {
    logic       ptrLoad;
    logic       regWrite;
    logic       readLoad;
    logic       readEnd;
    logic [7:0] wrByte;
  } busStrobe_t;

  localparam logic [7:0] REG_X     = 8'h00;
  localparam logic [7:0] REG_Y     = 8'h01;
  localparam logic [7:0] REG_Z     = 8'h02;
  localparam logic [7:0] REG_TILT  = 8'h03;
  localparam logic [7:0] REG_SETUP = 8'h06;
  localparam logic [7:0] REG_MODE  = 8'h07;

  localparam int EN_FB    = 0;
  localparam int EN_SIDE  = 1;
  localparam int EN_TAP   = 2;
  localparam int EN_WAKE  = 3;
  localparam int EN_EVERY = 4;

  localparam int MD_ACTIVE = 0;
  localparam int MD_TEST   = 2;
  localparam int MD_WAKE   = 3;
  localparam int MD_SLEEP  = 4;
  localparam int MD_PRESC  = 5;
  localparam int MD_PUSH   = 6;
  localparam int MD_HIGH   = 7;
endpackage

// File: rtl/accel_bus_ctl.sv
module accel_bus_ctl
  import accel_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output logic       sdaLow,
  output busStrobe_t strb
);
  localparam int SH_W = SYNC_STAGES + 1;

  typedef enum logic [2:0] {BUS_IDLE, BUS_RX, BUS_ACK, BUS_TX, BUS_MACK} busState_t;

  logic [SH_W-1:0] sclSh, sdaSh;
  logic scl, sclPrev, sda, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;
  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic isAddr, readDir, firstData, masterNack, driveLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
    end else begin
      sclSh <= {sclSh[SH_W-2:0], sclIn};
      sdaSh <= {sdaSh[SH_W-2:0], sdaIn};
    end
  end

  assign scl       = sclSh[SH_W-2];
  assign sclPrev   = sclSh[SH_W-1];
  assign sda       = sdaSh[SH_W-2];
  assign sdaPrev   = sdaSh[SH_W-1];
  assign sclRise   = scl & ~sclPrev;
  assign sclFall   = ~scl & sclPrev;
  assign startCond = scl & sclPrev & sdaPrev & ~sda;
  assign stopCond  = scl & sclPrev & ~sdaPrev & sda;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= BUS_IDLE;
      bitCnt     <= '0;
      shiftReg   <= '0;
      isAddr     <= 1'b0;
      readDir    <= 1'b0;
      firstData  <= 1'b0;
      masterNack <= 1'b0;
      driveLow   <= 1'b0;
      strb       <= '0;
    end else begin
      strb <= '0;
      if (startCond) begin
        if (state == BUS_TX || state == BUS_MACK) strb.readEnd <= 1'b1;
        state    <= BUS_RX;
        isAddr   <= 1'b1;
        bitCnt   <= '0;
        driveLow <= 1'b0;
      end else if (stopCond) begin
        if (state == BUS_TX || state == BUS_MACK) strb.readEnd <= 1'b1;
        state    <= BUS_IDLE;
        driveLow <= 1'b0;
      end else begin
        unique case (state)
          BUS_RX: begin
            if (sclRise && bitCnt != 4'd8) begin
              shiftReg <= {shiftReg[6:0], sda};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (isAddr) begin
                if (shiftReg[7:1] == DEV_ADDR) begin
                  driveLow  <= 1'b1;
                  state     <= BUS_ACK;
                  readDir   <= shiftReg[0];
                  firstData <= 1'b1;
                end else begin
                  state <= BUS_IDLE;
                end
              end else begin
                driveLow    <= 1'b1;
                state       <= BUS_ACK;
                strb.wrByte <= shiftReg;
                if (firstData) strb.ptrLoad <= 1'b1;
                else           strb.regWrite <= 1'b1;
                firstData   <= 1'b0;
              end
            end
          end
          BUS_ACK: begin
            if (sclFall) begin
              isAddr <= 1'b0;
              bitCnt <= '0;
              if (isAddr && readDir) begin
                state         <= BUS_TX;
                shiftReg      <= rdByte;
                driveLow      <= ~rdByte[7];
                strb.readLoad <= 1'b1;
              end else begin
                state    <= BUS_RX;
                driveLow <= 1'b0;
              end
            end
          end
          BUS_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                driveLow <= 1'b0;
                state    <= BUS_MACK;
              end else begin
                shiftReg <= {shiftReg[6:0], 1'b0};
                driveLow <= ~shiftReg[6];
                bitCnt   <= bitCnt + 4'd1;
              end
            end
          end
          BUS_MACK: begin
            if (sclRise) begin
              masterNack <= sda;
            end else if (sclFall) begin
              strb.readEnd <= 1'b1;
              bitCnt       <= '0;
              if (!masterNack) begin
                state         <= BUS_TX;
                shiftReg      <= rdByte;
                driveLow      <= ~rdByte[7];
                strb.readLoad <= 1'b1;
              end else begin
                state <= BUS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaLow = driveLow;

  // R1: the data line is only newly pulled low while the clock line is low
  assert_ack_drive_scl_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow && !$past(sdaLow)) |-> !scl);

  // R2: pointer load, register write and read load never coincide
  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ptrLoad, strb.regWrite, strb.readLoad}));
endmodule

// File: rtl/accel_regs.sv
module accel_regs
  import accel_pkg::*;
#(
  parameter int AXIS_W      = 6,
  parameter int AXES        = 3,
  parameter int SLEEP_LIMIT = 255,
  parameter int PRESC_LOG   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic              sampleStrobe,
  input  logic [AXIS_W-1:0] sampleIn [AXES],
  input  logic [AXES-1:0]   shakeStrobe,
  input  logic              tapStrobe,
  input  logic              orientStrobe,
  input  logic [1:0]        frontBackIn,
  input  logic [2:0]        sideIn,
  output logic [7:0]        rdByte,
  output logic              intOut,
  output logic              intOe,
  output logic              asleep
);
  localparam int SC_W = $clog2(SLEEP_LIMIT + 1);

  logic [7:0] ptr, setupReg, modeReg, busyIdx;
  logic       busy, pending, asleepR;
  logic [1:0] tiltFb;
  logic [2:0] tiltSide;
  logic       tiltTap, tiltShake;
  logic [AXIS_W-1:0] axisVal [AXES];
  logic [AXES-1:0]   axisAlert;
  logic [7:0]        axisByte [AXES];
  logic [PRESC_LOG-1:0] preCnt;
  logic [SC_W-1:0]      sleepCnt;

  logic activeNow, tiltRead, modeWrite;
  logic [AXES-1:0] shakeEn, shakeHit;
  logic sideChg, fbChg, activity, sleepStep, sleepTick, wakeEvt, evtAny;

  assign activeNow = modeReg[MD_ACTIVE] & ~modeReg[MD_TEST];
  assign tiltRead  = strb.readLoad && ptr == REG_TILT;
  assign modeWrite = strb.regWrite && ptr == REG_MODE;

  generate
    for (genvar k = 0; k < AXES; k++) begin : g_shakeEn
      assign shakeEn[k] = setupReg[7-k];
    end
  endgenerate

  assign shakeHit  = shakeStrobe & shakeEn;
  assign sideChg   = orientStrobe && sideIn != tiltSide;
  assign fbChg     = orientStrobe && frontBackIn != tiltFb;
  assign activity  = (|shakeStrobe) | tapStrobe | sideChg | fbChg;
  assign sleepStep = sampleStrobe && modeReg[MD_SLEEP] && !asleepR;
  assign sleepTick = sleepStep && (modeReg[MD_PRESC] ? (preCnt == '1) : 1'b1);
  assign wakeEvt   = activity && asleepR && modeReg[MD_WAKE];
  assign evtAny    = activeNow && ((|shakeHit)
                   | (sideChg & setupReg[EN_SIDE]) | (fbChg & setupReg[EN_FB])
                   | (tapStrobe & setupReg[EN_TAP]) | (sampleStrobe & setupReg[EN_EVERY])
                   | (wakeEvt & setupReg[EN_WAKE]));

  // pointer, writable registers, read tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      setupReg <= '0;
      modeReg  <= '0;
      busy     <= 1'b0;
      busyIdx  <= '0;
    end else begin
      if (strb.ptrLoad) begin
        ptr <= strb.wrByte;
      end else if (strb.regWrite) begin
        if (ptr == REG_SETUP) setupReg <= strb.wrByte;
        if (ptr == REG_MODE)  modeReg  <= strb.wrByte;
        ptr <= ptr + 8'd1;
      end else if (strb.readLoad) begin
        ptr <= ptr + 8'd1;
      end
      if (strb.readLoad) begin
        busy    <= 1'b1;
        busyIdx <= ptr;
      end else if (strb.readEnd) begin
        busy <= 1'b0;
      end
    end
  end

  // tilt status and interrupt latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tiltFb    <= '0;
      tiltSide  <= '0;
      tiltTap   <= 1'b0;
      tiltShake <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (activeNow && orientStrobe) begin
        tiltFb   <= frontBackIn;
        tiltSide <= sideIn;
      end
      if (activeNow && (|shakeHit)) tiltShake <= 1'b1;
      else if (tiltRead)            tiltShake <= 1'b0;
      if (activeNow && tapStrobe)   tiltTap <= 1'b1;
      else if (tiltRead)            tiltTap <= 1'b0;
      if (evtAny)        pending <= 1'b1;
      else if (tiltRead) pending <= 1'b0;
    end
  end

  // axis result registers with read hold-off
  generate
    for (genvar k = 0; k < AXES; k++) begin : g_axis
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          axisVal[k]   <= '0;
          axisAlert[k] <= 1'b0;
        end else if (activeNow && sampleStrobe) begin
          if (busy && busyIdx == 8'(k)) begin
            axisAlert[k] <= 1'b1;
          end else begin
            axisVal[k]   <= sampleIn[k];
            axisAlert[k] <= 1'b0;
          end
        end
      end
      assign axisByte[k] = 8'({axisAlert[k], axisVal[k]});

      // R4: an alert only appears while that axis register is being read
      assert_alert_needs_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
        $rose(axisAlert[k]) |-> $past(busy && busyIdx == 8'(k)));
    end
  endgenerate

  // sleep counter with prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      sleepCnt <= '0;
      asleepR  <= 1'b0;
    end else if (modeWrite) begin
      preCnt   <= '0;
      sleepCnt <= '0;
      asleepR  <= 1'b0;
    end else if (activeNow) begin
      if (activity) begin
        preCnt   <= '0;
        sleepCnt <= '0;
        if (wakeEvt) asleepR <= 1'b0;
      end else if (sleepStep) begin
        preCnt <= preCnt + 1'b1;
        if (sleepTick) begin
          if (sleepCnt == SC_W'(SLEEP_LIMIT - 1)) begin
            sleepCnt <= '0;
            asleepR  <= 1'b1;
          end else begin
            sleepCnt <= sleepCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    unique case (ptr)
      REG_X:     rdByte = axisByte[0];
      REG_Y:     rdByte = axisByte[1];
      REG_Z:     rdByte = axisByte[2];
      REG_TILT:  rdByte = {tiltShake, 1'b0, tiltTap, tiltSide, tiltFb};
      REG_SETUP: rdByte = setupReg;
      REG_MODE:  rdByte = modeReg;
      default:   rdByte = 8'h00;
    endcase
  end

  assign intOut = modeReg[MD_HIGH] ? pending : ~pending;
  assign intOe  = modeReg[MD_PUSH] | ~intOut;
  assign asleep = asleepR;

  // R11: outside the active state no interrupt can be latched
  assert_standby_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !activeNow |=> !$rose(pending));

  // R9: the pending flag only drops after a tilt register read
  assert_pending_clear_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pending) |-> $past(tiltRead));

  // R12: the sleep counter never reaches the limit value
  assert_sleep_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    sleepCnt < SC_W'(SLEEP_LIMIT));
endmodule

// File: rtl/accel_tilt_slave.sv
module accel_tilt_slave
  import accel_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C,
  parameter int AXIS_W      = 6,
  parameter int SLEEP_LIMIT = 255,
  parameter int PRESC_LOG   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaLow,
  input  logic              sampleStrobe,
  input  logic [AXIS_W-1:0] sampleX,
  input  logic [AXIS_W-1:0] sampleY,
  input  logic [AXIS_W-1:0] sampleZ,
  input  logic [2:0]        shakeStrobe,
  input  logic              tapStrobe,
  input  logic              orientStrobe,
  input  logic [1:0]        frontBackIn,
  input  logic [2:0]        sideIn,
  output logic              intOut,
  output logic              intOe,
  output logic              asleep
);
  busStrobe_t strb;
  logic [7:0] rdByte;
  logic [AXIS_W-1:0] sampleIn [3];

  assign sampleIn[0] = sampleX;
  assign sampleIn[1] = sampleY;
  assign sampleIn[2] = sampleZ;

  accel_bus_ctl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(2)) u_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .sdaLow(sdaLow), .strb(strb)
  );

  accel_regs #(.AXIS_W(AXIS_W), .AXES(3), .SLEEP_LIMIT(SLEEP_LIMIT),
               .PRESC_LOG(PRESC_LOG)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sampleStrobe(sampleStrobe), .sampleIn(sampleIn),
    .shakeStrobe(shakeStrobe), .tapStrobe(tapStrobe),
    .orientStrobe(orientStrobe), .frontBackIn(frontBackIn), .sideIn(sideIn),
    .rdByte(rdByte), .intOut(intOut), .intOe(intOe), .asleep(asleep)
  );
endmodule

// File: tb/sim_accel_tilt_slave.sv
`timescale 1ns/1ps
module sim_accel_tilt_slave;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaMLow = 1'b0;
  logic sdaLow;
  logic sampleStrobe = 1'b0;
  logic [5:0] sampleX = '0, sampleY = '0, sampleZ = '0;
  logic [2:0] shakeStrobe = '0;
  logic tapStrobe = 1'b0;
  logic orientStrobe = 1'b0;
  logic [1:0] frontBackIn = '0;
  logic [2:0] sideIn = '0;
  logic intOut, intOe, asleep;
  logic sdaBus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] rdBuf [8];
  logic [5:0] mX = '0, mY = '0, mZ = '0;

  always #2 clk = ~clk;
  assign sdaBus = ~(sdaMLow | sdaLow);

  accel_tilt_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaLow(sdaLow),
    .sampleStrobe(sampleStrobe), .sampleX(sampleX), .sampleY(sampleY), .sampleZ(sampleZ),
    .shakeStrobe(shakeStrobe), .tapStrobe(tapStrobe), .orientStrobe(orientStrobe),
    .frontBackIn(frontBackIn), .sideIn(sideIn),
    .intOut(intOut), .intOe(intOe), .asleep(asleep)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic i2cStart();
    sdaMLow = 1'b0; wt(H); sclM = 1'b1; wt(H);
    sdaMLow = 1'b1; wt(H); sclM = 1'b0; wt(2);
  endtask

  task automatic i2cStop();
    sdaMLow = 1'b1; wt(H); sclM = 1'b1; wt(H); sdaMLow = 1'b0; wt(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaMLow = ~b[i]; wt(H); sclM = 1'b1; wt(H); sclM = 1'b0; wt(2);
    end
    sdaMLow = 1'b0; wt(H); sclM = 1'b1; wt(H/2);
    ack = ~sdaBus;
    wt(H/2); sclM = 1'b0; wt(2);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    sdaMLow = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(H); sclM = 1'b1; wt(H/2);
      b = {b[6:0], sdaBus};
      wt(H/2); sclM = 1'b0; wt(2);
    end
    sdaMLow = giveAck; wt(H); sclM = 1'b1; wt(H); sclM = 1'b0; wt(2);
    sdaMLow = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] r, input logic [7:0] v, output logic ackAll);
    logic a0, a1, a2;
    i2cStart(); sendByte(8'h98, a0); sendByte(r, a1); sendByte(v, a2); i2cStop();
    ackAll = a0 & a1 & a2;
  endtask

  task automatic readRegs(input logic [7:0] r, input int n);
    logic a;
    logic [7:0] b;
    i2cStart(); sendByte(8'h98, a); sendByte(r, a);
    i2cStart(); sendByte(8'h99, a);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      rdBuf[i] = b;
    end
    i2cStop();
  endtask

  task automatic pulseSample(input logic [5:0] x, input logic [5:0] y, input logic [5:0] z);
    sampleX = x; sampleY = y; sampleZ = z; sampleStrobe = 1'b1; wt(1);
    sampleStrobe = 1'b0; wt(1);
  endtask

  task automatic pulseShake(input logic [2:0] s);
    shakeStrobe = s; wt(1); shakeStrobe = '0; wt(3);
  endtask

  task automatic pulseOrient(input logic [1:0] fb, input logic [2:0] sd);
    frontBackIn = fb; sideIn = sd; orientStrobe = 1'b1; wt(1);
    orientStrobe = 1'b0; wt(3);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic ok;
    logic a;
    logic [7:0] b;
    wt(5); rstN = 1'b1; wt(5);

    // R13: reset state
    chk("R13 intOut", {7'd0, intOut}, 8'd1);
    chk("R13 intOe", {7'd0, intOe}, 8'd0);
    chk("R13 sdaLow", {7'd0, sdaLow}, 8'd0);
    chk("R13 asleep", {7'd0, asleep}, 8'd0);

    // R1: foreign address is not acknowledged
    i2cStart(); sendByte(8'h90, a); i2cStop();
    chk("R1 foreign address ack", {7'd0, a}, 8'd0);

    // R2 R6: burst write 0x06,0x07 then burst read back
    i2cStart(); sendByte(8'h98, a); chk("R1 own address ack", {7'd0, a}, 8'd1);
    sendByte(8'h06, a); sendByte(8'hE3, a); sendByte(8'hD9, a); i2cStop();
    readRegs(8'h06, 2);
    chk("R6 setup readback", rdBuf[0], 8'hE3);
    chk("R2 burst next register", rdBuf[1], 8'hD9);

    writeReg(8'h07, 8'hC1, ok);
    wt(4);
    chk("R11 active-high idle level", {7'd0, intOut}, 8'd0);
    chk("R11 push-pull drive", {7'd0, intOe}, 8'd1);

    // R3: axis samples, burst read 0..2
    pulseSample(6'd5, 6'd33, 6'd63); mX = 6'd5; mY = 6'd33; mZ = 6'd63;
    readRegs(8'h00, 3);
    chk("R3 X", rdBuf[0], {2'b00, mX});
    chk("R3 Y", rdBuf[1], {2'b00, mY});
    chk("R3 Z", rdBuf[2], {2'b00, mZ});
    chk("R8 every-sample disabled", {7'd0, intOut}, 8'd0);

    // R7: enabled shake
    pulseShake(3'b001);
    chk("R7 shake raises int", {7'd0, intOut}, 8'd1);
    readRegs(8'h03, 1);
    chk("R7 shake bit set", rdBuf[0], 8'h80);
    wt(4);
    chk("R9 int clears on tilt read", {7'd0, intOut}, 8'd0);
    readRegs(8'h03, 1);
    chk("R9 shake bit cleared", rdBuf[0], 8'h00);

    // R7: disabled shake
    writeReg(8'h06, 8'h03, ok);
    pulseShake(3'b001);
    chk("R7 disabled shake no int", {7'd0, intOut}, 8'd0);
    readRegs(8'h03, 1);
    chk("R7 disabled shake no bit", rdBuf[0], 8'h00);

    // R8 R5: orientation change front + up
    pulseOrient(2'b01, 3'b110);
    chk("R8 orientation change int", {7'd0, intOut}, 8'd1);
    readRegs(8'h03, 1);
    chk("R5 tilt front/up", rdBuf[0], 8'h19);
    wt(4);
    pulseOrient(2'b01, 3'b110);
    chk("R8 repeated orientation no int", {7'd0, intOut}, 8'd0);

    // R8: every-sample interrupt
    writeReg(8'h06, 8'h10, ok);
    pulseSample(mX, mY, mZ);
    chk("R8 every-sample int", {7'd0, intOut}, 8'd1);
    readRegs(8'h03, 1);

    // R10: write to a read-only register
    writeReg(8'h00, 8'h2A, ok);
    chk("R10 ignored write acked", {7'd0, ok}, 8'd1);
    readRegs(8'h00, 1);
    chk("R10 X unchanged", rdBuf[0], {2'b00, mX});

    // R4: sample during a read of X
    writeReg(8'h06, 8'h00, ok);
    i2cStart(); sendByte(8'h98, a); sendByte(8'h00, a);
    i2cStart(); sendByte(8'h99, a);
    wt(10);
    pulseSample(6'd9, mY, mZ);
    recvByte(1'b0, b); i2cStop();
    chk("R4 byte in flight is old value", b, {2'b00, mX});
    readRegs(8'h00, 1);
    chk("R4 alert set, value held", rdBuf[0], {2'b01, mX});
    pulseSample(6'd9, mY, mZ); mX = 6'd9;
    readRegs(8'h00, 1);
    chk("R4 alert cleared, new value", rdBuf[0], {2'b00, mX});

    // R11: standby ignores events
    writeReg(8'h07, 8'hC0, ok);
    writeReg(8'h06, 8'hE3, ok);
    pulseShake(3'b001);
    pulseOrient(2'b10, 3'b001);
    chk("R11 standby no int", {7'd0, intOut}, 8'd0);
    readRegs(8'h03, 1);
    chk("R11 standby tilt unchanged", rdBuf[0], 8'h19);

    // R11: active-low open-drain
    writeReg(8'h07, 8'h01, ok);
    wt(4);
    chk("R11 active-low idle", {7'd0, intOut}, 8'd1);
    chk("R11 open-drain released", {7'd0, intOe}, 8'd0);
    pulseShake(3'b010);
    chk("R11 active-low asserted", {7'd0, intOut}, 8'd0);
    chk("R11 open-drain drives", {7'd0, intOe}, 8'd1);
    readRegs(8'h03, 1);
    wt(4);
    chk("R9 active-low released", {7'd0, intOut}, 8'd1);

    // R12: sleep counting without prescaler
    writeReg(8'h06, 8'h08, ok);
    writeReg(8'h07, 8'h19, ok);
    for (int i = 0; i < 254; i++) pulseSample(mX, mY, mZ);
    chk("R12 one short of limit", {7'd0, asleep}, 8'd0);
    pulseSample(mX, mY, mZ);
    chk("R12 asleep at limit", {7'd0, asleep}, 8'd1);
    pulseShake(3'b001);
    chk("R12 wake on activity", {7'd0, asleep}, 8'd0);
    chk("R12 sleep-exit int", {7'd0, intOut}, 8'd0);
    readRegs(8'h03, 1);
    chk("R7 wake shake disabled axis bit", rdBuf[0], 8'h19);

    // R12: prescaler divide by 16
    writeReg(8'h07, 8'h39, ok);
    for (int i = 0; i < 4079; i++) pulseSample(mX, mY, mZ);
    chk("R12 prescaled one short", {7'd0, asleep}, 8'd0);
    pulseSample(mX, mY, mZ);
    chk("R12 prescaled asleep", {7'd0, asleep}, 8'd1);

    // R5 R8: tap
    writeReg(8'h07, 8'h81, ok);
    writeReg(8'h06, 8'h04, ok);
    tapStrobe = 1'b1; wt(1); tapStrobe = 1'b0; wt(3);
    chk("R8 tap int", {7'd0, intOut}, 8'd1);
    readRegs(8'h03, 1);
    chk("R5 tap bit", rdBuf[0], 8'h39);
    readRegs(8'h03, 1);
    chk("R9 tap bit cleared", rdBuf[0], 8'h19);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule